// File: doc/BRIEF.md
# Data-Rate Oversampling Clock Prescaler

This block divides a fixed reference clock into an oversampling clock that runs at eight times the chosen network bit rate. A 3-bit select value `n` picks the rate: every phase (high or low) of the output lasts `BASE_HALF * 2^n` reference cycles. Select 0 gives the fastest rate and each step halves it, so select 4 is one sixteenth of the base rate. The output is a registered square wave `osClk`. It comes with a one-cycle enable `osTick` for logic that stays on the reference clock.

Software writes a new select value with a strobe, and a mode bit delivered with the write decides how the value reaches the divider. In raw mode the divider uses the value on the same edge that samples the write, and its counter is not restarted, so the phase in progress can be cut short. In synchronized mode the value passes through a chain of `SYNC_STAGES` flip-flops and a pending register. The divider picks it up only at its next counter wrap, so no output phase is shorter than the shorter of the old and new half-periods. While a synchronized value is in flight, the block lowers `rateLocked`. A fast-rate guard refuses raw writes of a nonzero select while `fastRate` is high, and it records each refusal in a sticky error flag.

Top module: `rate_prescaler`

## Requirements
- R1: After reset: `osClk`=0, `osTick`=0, `rateLocked`=1, `selErr`=0, and the divider runs with select 0 (each phase lasts `BASE_HALF` reference cycles).
- R2: Once the divider is settled on select `n` (0..7), every high phase and every low phase of `osClk` lasts exactly `BASE_HALF * 2^n` reference cycles.
- R3: `osTick` is high for exactly one cycle, in the cycle in which `osClk` is first seen high after a low phase, and is low in every other cycle.
- R4: A raw write (`cfgWr`=1, `cfgSync`=0) takes effect on the edge that samples it, and the phase counter keeps its count. With `BASE_HALF`=1, on select 4, a raw write of select 2 in the 10th cycle of a phase gives that phase a length of 11, and later phases a length of 4. A raw write also discards any synchronized value still in flight.
- R5: A synchronized write (`cfgWr`=1, `cfgSync`=1) changes the divider only at a counter wrap, after the value has crossed the stage chain. The phase in progress keeps its full old length. In the R4 scenario the phase in progress lasts 16 cycles and the following phases last 4.
- R6: `rateLocked` goes low in the cycle after a synchronized write is sampled. It stays low until the edge at which the value is committed, and it is high from the cycle after that edge.
- R7: A raw write with a nonzero select while `fastRate`=1 is ignored (the output rate does not change) and sets `selErr`. `selErr` stays set until reset. A raw write of select 0 under `fastRate`=1 is accepted.
- R8: When several synchronized writes are in flight, the most recent one wins. Values overtaken before a wrap never reach the divider, including when commits and new arrivals fall on the same edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Configuration write strobe, one cycle |
| cfgSel | input | 3 | Rate select value carried by the write |
| cfgSync | input | 1 | 1: synchronized write, 0: raw write |
| fastRate | input | 1 | Fast-rate guard; refuses nonzero raw selects |
| osClk | output | 1 | Divided oversampling clock (registered) |
| osTick | output | 1 | One-cycle pulse at each rising phase of `osClk` |
| rateLocked | output | 1 | Low while a synchronized select is in flight |
| selErr | output | 1 | Sticky flag for refused raw writes |

## Verification
The pending commit and the arrival of a newer synchronized value can fall on the same reference edge. The same holds for a raw write and an in-flight synchronized value. The bench provokes the first collision by issuing two synchronized writes back to back on select 0, where every cycle is a wrap. It provokes the second by putting a raw write right behind a synchronized one. In both cases the bench judges only the settled phase length and `rateLocked`: the last value written must be the one running, and no overtaken rate may appear. Phase lengths are measured from `osClk` alone, so the bench checks the cut phase of a raw change and the full phase of a synchronized change to the exact cycle.

// File: rtl/rate_prescaler_pkg.sv
package rate_prescaler_pkg;
  localparam int SEL_W = 3;
  typedef logic [SEL_W-1:0] sel_t;

  // Strobe bundle from control to datapath.
  typedef struct packed {
    logic load;
    sel_t sel;
  } rateCmd_t;
endpackage

// File: rtl/rate_divider_dp.sv
module rate_divider_dp
  import rate_prescaler_pkg::*;
#(
  parameter int BASE_HALF = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  rateCmd_t cmd,
  output logic     osClk,
  output logic     osTick,
  output logic     wrapNow
);
  localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF) + 1;

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] halfLimit;
  sel_t             curSel;

  always_comb halfLimit = (CNT_W'(BASE_HALF) << curSel) - CNT_W'(1);

  // ">=" so that a raw shrink of the limit ends the phase at once.
  assign wrapNow = (phaseCnt >= halfLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      osClk    <= 1'b0;
      osTick   <= 1'b0;
    end else begin
      osTick <= wrapNow && !osClk;
      if (wrapNow) begin
        phaseCnt <= '0;
        osClk    <= ~osClk;
      end else begin
        phaseCnt <= phaseCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curSel <= '0;
    else if (cmd.load) curSel <= cmd.sel;
  end

  // R2: each wrap flips the output, and the output holds between wraps.
  a_r2_wrap_flips: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> (osClk != $past(osClk)));
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !wrapNow |=> $stable(osClk));
  // R3: the tick marks rising phases only.
  a_r3_tick_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(osClk) |-> osTick);
  a_r3_tick_only_rise: assert property (@(posedge clk) disable iff (!rstN)
    osTick |-> osClk);
endmodule

// File: rtl/rate_cfg_ctrl.sv
module rate_cfg_ctrl
  import rate_prescaler_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWr,
  input  sel_t     cfgSel,
  input  logic     cfgSync,
  input  logic     fastRate,
  input  logic     wrapNow,
  output rateCmd_t cmd,
  output logic     rateLocked,
  output logic     selErr
);
  localparam int LAST = SYNC_STAGES - 1;

  logic stgVld [SYNC_STAGES];
  sel_t stgSel [SYNC_STAGES];
  logic pendVld;
  sel_t pendSel;
  logic syncWr, rawWr, rawBlocked, rawAccept, commit, anyStage;

  assign syncWr     = cfgWr && cfgSync;
  assign rawWr      = cfgWr && !cfgSync;
  assign rawBlocked = rawWr && fastRate && (cfgSel != '0);
  assign rawAccept  = rawWr && !rawBlocked;
  assign commit     = pendVld && wrapNow && !rawAccept;

  // Synchronizer chain; a raw write flushes it.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stgVld[g] <= 1'b0;
          stgSel[g] <= '0;
        end else begin
          stgVld[g] <= syncWr && !rawAccept;
          stgSel[g] <= cfgSel;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stgVld[g] <= 1'b0;
          stgSel[g] <= '0;
        end else begin
          stgVld[g] <= stgVld[g-1] && !rawAccept;
          stgSel[g] <= stgSel[g-1];
        end
      end
    end
  end

  // Pending register: the newest arrival replaces any older value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendVld <= 1'b0;
      pendSel <= '0;
    end else if (rawAccept) begin
      pendVld <= 1'b0;
    end else if (stgVld[LAST]) begin
      pendVld <= 1'b1;
      pendSel <= stgSel[LAST];
    end else if (commit) begin
      pendVld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selErr <= 1'b0;
    else if (rawBlocked) selErr <= 1'b1;
  end

  always_comb begin
    anyStage = 1'b0;
    for (int i = 0; i < SYNC_STAGES; i++) anyStage = anyStage | stgVld[i];
  end

  assign rateLocked = !anyStage && !pendVld;
  assign cmd.load   = rawAccept || commit;
  assign cmd.sel    = rawAccept ? cfgSel : pendSel;

  // R5: a load not caused by a raw write only happens at a divider wrap.
  a_r5_load_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && !(cfgWr && !cfgSync)) |-> wrapNow);
  // R6: a synchronized write drops the lock status in the next cycle.
  a_r6_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgSync) |=> !rateLocked);
  // R7: refused writes never load, and they raise the flag.
  a_r7_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgSync && fastRate && cfgSel != '0) |-> !cmd.load);
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgSync && fastRate && cfgSel != '0) |=> selErr);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    selErr |=> selErr);
endmodule

// File: rtl/rate_prescaler.sv
module rate_prescaler
  import rate_prescaler_pkg::*;
#(
  parameter int BASE_HALF   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic [2:0] cfgSel,
  input  logic       cfgSync,
  input  logic       fastRate,
  output logic       osClk,
  output logic       osTick,
  output logic       rateLocked,
  output logic       selErr
);
  rateCmd_t rateCmd;
  logic     wrapNow;

  rate_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWr),
    .cfgSel     (cfgSel),
    .cfgSync    (cfgSync),
    .fastRate   (fastRate),
    .wrapNow    (wrapNow),
    .cmd        (rateCmd),
    .rateLocked (rateLocked),
    .selErr     (selErr)
  );

  rate_divider_dp #(.BASE_HALF(BASE_HALF)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (rateCmd),
    .osClk   (osClk),
    .osTick  (osTick),
    .wrapNow (wrapNow)
  );
endmodule

// File: tb/rate_prescaler_tb.sv
`timescale 1ns/1ps
module rate_prescaler_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic [2:0] cfgSel = 3'd0;
  logic       cfgSync = 1'b0;
  logic       fastRate = 1'b0;
  logic       osClk, osTick, rateLocked, selErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  rate_prescaler u_dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgSel(cfgSel),
    .cfgSync(cfgSync), .fastRate(fastRate), .osClk(osClk),
    .osTick(osTick), .rateLocked(rateLocked), .selErr(selErr)
  );

  always #4 clk = ~clk;

  // Phase monitor: run lengths of osClk and tick consistency.
  logic prevClk = 1'b0;
  int   runLen = 0;
  int   phaseCount = 0;
  int   phaseLog [2048];
  int   tickErr = 0;
  int   tickSeen = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      runLen  = 0;
      prevClk = osClk;
    end else begin
      if (osTick != (osClk && !prevClk)) tickErr++;
      if (osTick) tickSeen++;
      if (osClk != prevClk) begin
        phaseLog[phaseCount % 2048] = runLen;
        phaseCount++;
        runLen = 1;
      end else begin
        runLen++;
      end
      prevClk = osClk;
    end
  end

  function automatic int ph(int idx);
    return phaseLog[idx % 2048];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitPhases(input int k);
    int start = phaseCount;
    while (phaseCount < start + k) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wrRaw(input int sel);
    cfgWr = 1'b1; cfgSync = 1'b0; cfgSel = 3'(sel);
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic wrSync(input int sel);
    cfgWr = 1'b1; cfgSync = 1'b1; cfgSel = 3'(sel);
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    rstN = 1'b1;
  endtask

  task automatic tReset();
    doReset();
    check(osClk == 1'b0, "R1 osClk", osClk, 0);
    check(osTick == 1'b0, "R1 osTick", osTick, 0);
    check(rateLocked == 1'b1, "R1 rateLocked", rateLocked, 1);
    check(selErr == 1'b0, "R1 selErr", selErr, 0);
    waitPhases(3);
    check(ph(phaseCount - 1) == 1, "R1 default phase", ph(phaseCount - 1), 1);
  endtask

  task automatic tRates();
    for (int n = 0; n < 8; n++) begin
      wrRaw(n);
      waitPhases(3);
      check(ph(phaseCount - 1) == (1 << n), "R2 phase length",
            ph(phaseCount - 1), 1 << n);
    end
  endtask

  task automatic tRawCut();
    int s;
    wrRaw(4);
    waitPhases(3);
    waitPhases(1);
    repeat (9) @(negedge clk);
    #1;
    wrRaw(2);
    s = phaseCount;
    waitPhases(3);
    check(ph(s) == 11, "R4 cut phase", ph(s), 11);
    check(ph(s + 1) == 4, "R4 new phase", ph(s + 1), 4);
  endtask

  task automatic tSyncClean();
    int s;
    wrRaw(4);
    waitPhases(3);
    waitPhases(1);
    repeat (9) @(negedge clk);
    #1;
    wrSync(2);
    s = phaseCount;
    check(rateLocked == 1'b0, "R6 unlock after write", rateLocked, 0);
    repeat (5) @(negedge clk);
    #1;
    check(rateLocked == 1'b0, "R6 still unlocked before wrap", rateLocked, 0);
    @(negedge clk);
    #1;
    check(rateLocked == 1'b1, "R6 locked after commit", rateLocked, 1);
    waitPhases(3);
    check(ph(s) == 16, "R5 full old phase", ph(s), 16);
    check(ph(s + 1) == 4, "R5 new phase", ph(s + 1), 4);
    check(ph(s + 2) == 4, "R5 steady phase", ph(s + 2), 4);
  endtask

  task automatic tLastWins();
    int s;
    wrRaw(4);
    waitPhases(3);
    waitPhases(1);
    wrSync(3);
    wrSync(1);
    s = phaseCount;
    waitPhases(4);
    check(ph(s) == 16, "R8 old phase kept", ph(s), 16);
    check(ph(s + 1) == 2, "R8 newest value used", ph(s + 1), 2);
    check(ph(s + 2) == 2, "R8 no overtaken rate", ph(s + 2), 2);
    check(rateLocked == 1'b1, "R8 locked", rateLocked, 1);
  endtask

  task automatic tCollide();
    wrRaw(0);
    waitPhases(2);
    wrSync(2);
    wrSync(1);
    waitPhases(6);
    check(ph(phaseCount - 1) == 2, "R8 back-to-back on wraps", ph(phaseCount - 1), 2);
    check(ph(phaseCount - 2) == 2, "R8 back-to-back steady", ph(phaseCount - 2), 2);
    // A raw write flushes a synchronized value in flight (R4).
    wrSync(5);
    wrRaw(0);
    waitPhases(6);
    check(ph(phaseCount - 1) == 1, "R4 raw flushes sync", ph(phaseCount - 1), 1);
    check(rateLocked == 1'b1, "R4 locked after flush", rateLocked, 1);
  endtask

  task automatic tFast();
    wrRaw(0);
    waitPhases(2);
    fastRate = 1'b1;
    check(selErr == 1'b0, "R7 flag clear", selErr, 0);
    wrRaw(3);
    check(selErr == 1'b1, "R7 flag set", selErr, 1);
    waitPhases(4);
    check(ph(phaseCount - 1) == 1, "R7 write ignored", ph(phaseCount - 1), 1);
    wrRaw(0);
    waitPhases(3);
    check(ph(phaseCount - 1) == 1, "R7 zero accepted", ph(phaseCount - 1), 1);
    check(selErr == 1'b1, "R7 flag sticky", selErr, 1);
    fastRate = 1'b0;
    wrRaw(2);
    waitPhases(3);
    check(ph(phaseCount - 1) == 4, "R7 guard released", ph(phaseCount - 1), 4);
    check(selErr == 1'b1, "R7 flag still sticky", selErr, 1);
    doReset();
    check(selErr == 1'b0, "R7 flag cleared by reset", selErr, 0);
  endtask

  task automatic tTicks();
    check(tickErr == 0, "R3 tick mismatches", tickErr, 0);
    check(tickSeen > 0, "R3 ticks present", tickSeen, 1);
  endtask

  initial begin
    tReset();
    tRates();
    tRawCut();
    tSyncClean();
    tLastWins();
    tCollide();
    tFast();
    tTicks();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule